// File: doc/BRIEF.md
# Y-Extended Saturating Divider

This block divides a 64-bit dividend by a 32-bit divisor over many clock cycles and returns a quotient clamped to a 32-bit range. The upper half of the dividend is not taken from the first operand. It comes from a separate Y input, and the low 32 bits of the first operand fill the lower half. The dividend is therefore `{y_i, opa_i}`.

The caller pulses `start_i` with the operands and mode bits and then waits for `done_o`. Unsigned mode produces a zero-extended 32-bit quotient. Signed mode produces a sign-extended one. A quotient that does not fit is clamped to a fixed limit instead of being truncated. In flag mode the clamp event is also reported on the overflow flag. A zero divisor is reported as a fault right away, and no result is written.

Internally the block takes magnitudes of the operands and runs a one-bit-per-cycle restoring division. It then applies the sign and the clamp in a final cycle.

Top module: `ydiv_unit`

## Requirements
- R1: Unsigned mode (`signed_i`=0) divides `{y_i, opa_i}` by `divisor_i`. When the quotient fits in 32 bits, `quot_o` carries it in bits 31:0 with bits 63:32 zero.
- R2: Signed mode (`signed_i`=1) treats `{y_i, opa_i}` and `divisor_i` as two's-complement values and truncates toward zero. A quotient in [-2^31, 2^31-1] appears on `quot_o` sign-extended to 64 bits.
- R3: A zero divisor makes `done_o` and `dz_fault_o` high in the cycle after the edge that samples `start_i`. `busy_o` stays low, `quot_o` keeps its previous value and `flags_o` reads zero.
- R4: In unsigned mode, a quotient with any bit above bit 31 set gives `quot_o` = 64'h00000000_FFFFFFFF.
- R5: In signed mode, a quotient above 2^31-1 gives `quot_o` = 64'h00000000_7FFFFFFF.
- R6: In signed mode, a quotient below -2^31 gives `quot_o` = 64'hFFFFFFFF_80000000.
- R7: `flags_o` is {negative, zero, overflow, carry} (bit 3 down to bit 0). In flag mode (`setcc_i`=1), bit 1 equals the clamp condition of R4 to R6 and the other bits are zero. With `setcc_i`=0, all of `flags_o` is zero.
- R8: For a nonzero divisor, `busy_o` is high from the cycle after the start edge until `done_o` rises. `done_o` is high for exactly one cycle, following the 66th rising edge when the start edge is counted as the first.
- R9: `start_i` is ignored while `busy_o` is high. The running operation completes on schedule with its own result, and no second completion follows.
- R10: A completion with a nonzero divisor has `dz_fault_o` low.
- R11: `quot_o`, `flags_o` and `dz_fault_o` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| signed_i | input | 1 | 1 = two's-complement division |
| setcc_i | input | 1 | 1 = report clamp on the overflow flag |
| y_i | input | 32 | Upper half of the dividend |
| opa_i | input | 32 | Lower half of the dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 64 | Clamped, extended quotient |
| dz_fault_o | output | 1 | Zero divisor fault of the last completion |
| flags_o | output | 4 | {negative, zero, overflow, carry} |

## Verification
Most internal faults in this block show up at the ports only at the next completion, 66 cycles after the start edge. A wrong iteration count shifts the `done_o` pulse. A bad shift or subtract step corrupts the quotient, and a wrong sign bit flips or wrongly clamps it. The tests therefore place dividends on both sides of each clamp limit, in particular exactly -2^31 and exactly 2^31. A restart caused by a start pulse during a run would show as a late completion, or a second one, with the wrong operand's result.

// File: rtl/ydiv_pkg.sv
package ydiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ydiv_state_e;

    // flag vector bit positions
    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int FLG_W = 4;

endpackage

// File: rtl/ydiv_operand_prep.sv
module ydiv_operand_prep #(
    parameter int DATA_W = 32
) (
    input  logic                  signed_i,
    input  logic [DATA_W-1:0]     y_i,
    input  logic [DATA_W-1:0]     opa_i,
    input  logic [DATA_W-1:0]     divisor_i,
    output logic [2*DATA_W-1:0]   mag_dvd_o,
    output logic [DATA_W-1:0]     mag_dvs_o,
    output logic                  neg_o,
    output logic                  dvs_zero_o
);
    localparam int DW = 2 * DATA_W;

    logic [DW-1:0] dvd;
    logic          dvd_neg;
    logic          dvs_neg;

    always_comb begin
        dvd        = {y_i, opa_i};
        dvd_neg    = signed_i & dvd[DW-1];
        dvs_neg    = signed_i & divisor_i[DATA_W-1];
        mag_dvd_o  = dvd_neg ? (~dvd + DW'(1)) : dvd;
        mag_dvs_o  = dvs_neg ? (~divisor_i + DATA_W'(1)) : divisor_i;
        neg_o      = dvd_neg ^ dvs_neg;
        dvs_zero_o = (divisor_i == '0);
    end
endmodule

// File: rtl/ydiv_step.sv
module ydiv_step #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   rem_i,
    input  logic [2*DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0]   dvs_i,
    output logic [DATA_W-1:0]   rem_o,
    output logic [2*DATA_W-1:0] quo_o
);
    localparam int DW = 2 * DATA_W;

    logic [DATA_W:0]   r_sh;
    logic [DATA_W-1:0] diff;
    logic              fits;

    always_comb begin
        r_sh  = {rem_i, quo_i[DW-1]};
        fits  = r_sh >= {1'b0, dvs_i};
        diff  = r_sh[DATA_W-1:0] - dvs_i;
        rem_o = fits ? diff : r_sh[DATA_W-1:0];
        quo_o = {quo_i[DW-2:0], fits};
    end
endmodule

// File: rtl/ydiv_saturate.sv
module ydiv_saturate #(
    parameter int DATA_W = 32
) (
    input  logic                signed_i,
    input  logic                neg_i,
    input  logic [2*DATA_W-1:0] mag_i,
    output logic [2*DATA_W-1:0] res_o,
    output logic                sat_o
);
    localparam int DW = 2 * DATA_W;
    localparam logic [DW-1:0] U_LIMIT = {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
    localparam logic [DW-1:0] P_LIMIT = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [DW-1:0] N_LIMIT = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic hi_any;
    logic pos_big;
    logic neg_big;

    always_comb begin
        hi_any  = |mag_i[DW-1:DATA_W];
        pos_big = hi_any | mag_i[DATA_W-1];
        neg_big = hi_any | (mag_i[DATA_W-1] & (|mag_i[DATA_W-2:0]));
        if (!signed_i) begin
            sat_o = hi_any;
            res_o = hi_any ? U_LIMIT : {{DATA_W{1'b0}}, mag_i[DATA_W-1:0]};
        end else if (neg_i) begin
            sat_o = neg_big;
            res_o = neg_big ? N_LIMIT : (~mag_i + DW'(1));
        end else begin
            sat_o = pos_big;
            res_o = pos_big ? P_LIMIT : mag_i;
        end
    end
endmodule

// File: rtl/ydiv_unit.sv
module ydiv_unit
    import ydiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                signed_i,
    input  logic                setcc_i,
    input  logic [DATA_W-1:0]   y_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   divisor_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [2*DATA_W-1:0] quot_o,
    output logic                dz_fault_o,
    output logic [FLG_W-1:0]    flags_o
);
    localparam int DW    = 2 * DATA_W;
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(DW - 1);

    typedef struct packed {
        ydiv_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rem;
        logic [DW-1:0]     quo;
        logic [DATA_W-1:0] dvs;
        logic              neg;
        logic              sgn;
        logic              setf;
        logic              done;
        logic              dz;
        logic [DW-1:0]     res;
        logic [FLG_W-1:0]  flags;
    } regs_t;

    regs_t r_q, r_d;

    logic [DW-1:0]     mag_dvd;
    logic [DATA_W-1:0] mag_dvs;
    logic              op_neg;
    logic              dvs_zero;
    logic [DATA_W-1:0] step_rem;
    logic [DW-1:0]     step_quo;
    logic [DW-1:0]     sat_res;
    logic              sat_hit;

    ydiv_operand_prep #(.DATA_W(DATA_W)) i_prep (
        .signed_i   (signed_i),
        .y_i        (y_i),
        .opa_i      (opa_i),
        .divisor_i  (divisor_i),
        .mag_dvd_o  (mag_dvd),
        .mag_dvs_o  (mag_dvs),
        .neg_o      (op_neg),
        .dvs_zero_o (dvs_zero)
    );

    ydiv_step #(.DATA_W(DATA_W)) i_step (
        .rem_i (r_q.rem),
        .quo_i (r_q.quo),
        .dvs_i (r_q.dvs),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    ydiv_saturate #(.DATA_W(DATA_W)) i_sat (
        .signed_i (r_q.sgn),
        .neg_i    (r_q.neg),
        .mag_i    (r_q.quo),
        .res_o    (sat_res),
        .sat_o    (sat_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (dvs_zero) begin
                        r_d.done  = 1'b1;
                        r_d.dz    = 1'b1;
                        r_d.flags = '0;
                    end else begin
                        r_d.st   = ST_RUN;
                        r_d.cnt  = '0;
                        r_d.rem  = '0;
                        r_d.quo  = mag_dvd;
                        r_d.dvs  = mag_dvs;
                        r_d.neg  = op_neg;
                        r_d.sgn  = signed_i;
                        r_d.setf = setcc_i;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem = step_rem;
                r_d.quo = step_quo;
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == LAST_IT) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.res          = sat_res;
                r_d.dz           = 1'b0;
                r_d.flags        = '0;
                r_d.flags[FLG_V] = r_q.setf & sat_hit;
                r_d.done         = 1'b1;
                r_d.st           = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign quot_o     = r_q.res;
    assign dz_fault_o = r_q.dz;
    assign flags_o    = r_q.flags;

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_fault_o) |=> (!done_o || dz_fault_o));

    // R3
    dz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_fault_o) |-> (quot_o == $past(quot_o)));

    // R3
    dz_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_fault_o) |-> (!$past(busy_o) && flags_o == '0));

    // R7
    flag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!flags_o[FLG_N] && !flags_o[FLG_Z] && !flags_o[FLG_C]));

    // R4
    unsigned_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_fault_o && !r_q.sgn) |-> (quot_o[DW-1:DATA_W] == '0));

    // R9
    run_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |=> (r_q.st != ST_IDLE && r_q.cnt != '0 ||
                                r_q.st == ST_FIN));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (quot_o == $past(quot_o) && flags_o == $past(flags_o)));

endmodule

// File: tb/test_ydiv_unit.sv
`timescale 1ns/1ps
module test_ydiv_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0;
    logic        setf = 1'b0;
    logic [31:0] y = '0;
    logic [31:0] a = '0;
    logic [31:0] d = '0;
    logic        busy;
    logic        done;
    logic [63:0] quot;
    logic        dz;
    logic [3:0]  flags;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ydiv_unit i_ydiv_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .signed_i   (sgn),
        .setcc_i    (setf),
        .y_i        (y),
        .opa_i      (a),
        .divisor_i  (d),
        .busy_o     (busy),
        .done_o     (done),
        .quot_o     (quot),
        .dz_fault_o (dz),
        .flags_o    (flags)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // returns {sat, result}
    function automatic logic [64:0] model(input logic s, input logic [31:0] yy,
                                          input logic [31:0] aa, input logic [31:0] dd);
        logic [63:0] uq;
        longint      dv;
        longint      ds;
        longint      sq;
        if (!s) begin
            uq = {yy, aa} / {32'b0, dd};
            if (uq[63:32] != 0) return {1'b1, 64'h00000000FFFFFFFF};
            return {1'b0, uq};
        end
        dv = $signed({yy, aa});
        ds = longint'($signed(dd));
        sq = dv / ds;
        if (sq > 64'sd2147483647)  return {1'b1, 64'h000000007FFFFFFF};
        if (sq < -64'sd2147483648) return {1'b1, 64'hFFFFFFFF80000000};
        return {1'b0, sq};
    endfunction

    // issue one operation, return rising edges up to and including the done edge
    task automatic issue(input logic s, input logic f, input logic [31:0] yy,
                         input logic [31:0] aa, input logic [31:0] dd, output int lat);
        @(negedge clk);
        sgn = s; setf = f; y = yy; a = aa; d = dd; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input string req, input logic s, input logic f,
                            input logic [31:0] yy, input logic [31:0] aa,
                            input logic [31:0] dd);
        int          lat;
        logic [64:0] m;
        logic [3:0]  ef;
        m  = model(s, yy, aa, dd);
        ef = f ? {2'b00, m[64], 1'b0} : 4'b0000;
        issue(s, f, yy, aa, dd, lat);
        chk(req, "quotient", quot, m[63:0]);
        chk("R7", "flags", {60'b0, flags}, {60'b0, ef});
        chk("R10", "dz_fault", {63'b0, dz}, 64'd0);
        chk("R8", "latency", 64'(lat), 64'd66);
        chk("R8", "busy at done", {63'b0, busy}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R11", "reset busy", {63'b0, busy}, 64'd0);
        chk("R11", "reset done", {63'b0, done}, 64'd0);
        chk("R11", "reset quot", quot, 64'd0);
        chk("R11", "reset dz", {63'b0, dz}, 64'd0);
        chk("R11", "reset flags", {60'b0, flags}, 64'd0);
    endtask

    task automatic t_unsigned();
        run_case("R1", 1'b0, 1'b0, 32'h0, 32'd100, 32'd7);
        run_case("R1", 1'b0, 1'b1, 32'h1, 32'h0, 32'd4);
        run_case("R1", 1'b0, 1'b0, 32'h0, 32'hFFFFFFFF, 32'd1);
        run_case("R1", 1'b0, 1'b1, 32'h7, 32'h12345678, 32'hFFFFFFFF);
    endtask

    task automatic t_unsigned_sat();
        run_case("R4", 1'b0, 1'b1, 32'h5, 32'h0, 32'd2);
        run_case("R4", 1'b0, 1'b0, 32'h5, 32'h0, 32'd2);
        run_case("R4", 1'b0, 1'b1, 32'h1, 32'h0, 32'd1);
    endtask

    task automatic t_signed();
        run_case("R2", 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'd7);
        run_case("R2", 1'b1, 1'b1, 32'h0, 32'd100, 32'hFFFFFFF9);
        run_case("R2", 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9);
        run_case("R2", 1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1);
        run_case("R2", 1'b1, 1'b1, 32'h0, 32'h7FFFFFFF, 32'd1);
    endtask

    task automatic t_signed_sat();
        run_case("R5", 1'b1, 1'b1, 32'h1, 32'h0, 32'd1);
        run_case("R5", 1'b1, 1'b1, 32'h0, 32'h80000000, 32'd1);
        run_case("R6", 1'b1, 1'b1, 32'h1, 32'h0, 32'hFFFFFFFF);
        run_case("R6", 1'b1, 1'b0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'd1);
    endtask

    task automatic t_dz();
        int          lat;
        logic [63:0] prev;
        bit          saw_busy;
        prev = quot;
        saw_busy = 0;
        fork
            issue(1'b1, 1'b1, 32'h3, 32'h4, 32'h0, lat);
            begin
                repeat (3) begin
                    @(negedge clk);
                    if (busy) saw_busy = 1;
                end
            end
        join
        chk("R3", "dz latency", 64'(lat), 64'd1);
        chk("R3", "dz fault", {63'b0, dz}, 64'd1);
        chk("R3", "dz quot kept", quot, prev);
        chk("R3", "dz flags", {60'b0, flags}, 64'd0);
        chk("R3", "dz busy", {63'b0, saw_busy}, 64'd0);
        @(negedge clk);
        chk("R11", "dz held", {63'b0, dz}, 64'd1);
        run_case("R10", 1'b0, 1'b0, 32'h0, 32'd9, 32'd3);
    endtask

    task automatic t_busy_start();
        int          lat;
        int          extra;
        logic [64:0] m;
        m = model(1'b0, 32'h0, 32'd1000, 32'd10);
        @(negedge clk);
        sgn = 1'b0; setf = 1'b0; y = 32'h0; a = 32'd1000; d = 32'd10; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy after start", {63'b0, busy}, 64'd1);
        repeat (10) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        sgn = 1'b1; y = 32'h0; a = 32'd77; d = 32'h0; start = 1'b1;
        @(posedge clk);
        lat++;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy kept", {63'b0, busy}, 64'd1);
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk("R9", "latency unchanged", 64'(lat), 64'd66);
        chk("R9", "first result", quot, m[63:0]);
        chk("R9", "no fault", {63'b0, dz}, 64'd0);
        extra = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9", "no second completion", 64'(extra), 64'd0);
        chk("R11", "result held", quot, m[63:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unsigned();
        t_unsigned_sat();
        t_signed();
        t_signed_sat();
        t_dz();
        t_busy_start();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule